// File: doc/BRIEF.md
# Serial Transmit Queue Controller

This block buffers bytes from a host on their way to a serial transmit shift register. The host writes bytes one at a time. The block holds them in a small queue and hands them to the shifter through a one-cycle load strobe with its data. The shifter answers with a completion strobe at the end of each character, and the block then reloads the shifter with the next waiting byte. Three status outputs follow the queue: a room-available flag, a line-drained flag and a transmit interrupt level.

The parameter `ENHANCED` selects the queue depth. The basic build has a single slot, and its fullness comes from the room-available flag alone. The enhanced build has four slots with wrapping pointers. In the enhanced build the host can also pick an interrupt policy that fires only once the queue is fully empty.

The block also releases the request-to-send line once the transmitter drains. It holds a requested bit-rate divisor back until the next character boundary.

Top module: `txq_ctrl`

## Requirements
- R1: The basic build (`ENHANCED`=0) has one slot and holds at most one waiting byte. The enhanced build (`ENHANCED`=1) has four slots with pointers that wrap at four, and holds at most three waiting bytes. A byte that is inside the shifter does not count as waiting.
- R2: A write that arrives while `tbe` is 0 and the queue is full is discarded, and the discarded byte is never presented on `sh_data`.
- R3: `tbe` is 1 exactly when another byte can be accepted. In the basic build an accepted write clears it. In the enhanced build an accepted write clears it only when the queue has just become full.
- R4: Every accepted write leaves `all_sent` at 0 on the next cycle.
- R5: An accepted write made while `tx_enable` is 1 and the shifter is idle produces an `sh_load` pulse on the next cycle. The pulse carries the oldest waiting byte and frees its slot, so `tbe` is 1.
- R6: On `sh_done` with `tx_enable`=1 and `send_break`=0, a waiting byte is loaded into the shifter on the next cycle and its slot is freed. With nothing waiting, `all_sent` is set instead.
- R7: While `rts_ctl`=1, `rts_n` is 0. While `rts_ctl`=0, `rts_n` goes to 1 on the cycle after a completion that finds nothing waiting, and otherwise keeps its value.
- R8: With `int_enable`=1, each write attempt and each completion handled under R6 raises `tx_irq` when `tbe` is 1 afterwards. In the enhanced build with `empty_irq_mode`=1, the condition is instead that no byte is waiting.
- R9: `tx_irq` never rises except on the cycle after a write attempt or completion made with `int_enable`=1. Enabling interrupts alone raises nothing.
- R10: A value given with `baud_req` appears on `baud_div` only on the cycle after the next `sh_done`.
- R11: `tx_irq` is a level. It is cleared by `irq_ack` or by an accepted write, unless the same write raises it again.
- R12: After reset, `tbe`=1, `all_sent`=1, `tx_irq`=0, `rts_n`=1, `sh_load`=0, the queue is empty and `baud_div` equals `BAUD_RST`.
- R13: A completion that arrives while `tx_enable`=0 or `send_break`=1 loads nothing and leaves the shifter idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | DW | Host byte |
| tx_enable | input | 1 | Transmitter enable |
| send_break | input | 1 | Break in progress; blocks reloads |
| int_enable | input | 1 | Transmit interrupt enable |
| empty_irq_mode | input | 1 | Enhanced build: interrupt only when queue is empty |
| irq_ack | input | 1 | Clears the interrupt level |
| rts_ctl | input | 1 | Request-to-send control bit (1 asserts line) |
| baud_req | input | 1 | Strobe for a new divisor |
| baud_val | input | BW | Requested divisor |
| sh_done | input | 1 | Character complete from the shifter |
| sh_load | output | 1 | Load strobe to the shifter |
| sh_data | output | DW | Byte for the shifter |
| tbe | output | 1 | Room available in the queue |
| all_sent | output | 1 | Transmitter drained |
| tx_irq | output | 1 | Transmit interrupt level |
| rts_n | output | 1 | Request-to-send, active low |
| baud_div | output | BW | Divisor in effect |

## Verification
A wrong pointer or a stale `tbe` shows up at the ports within a character. Depending on the fault, `sh_data` carries a byte out of order, repeats a byte, or carries one that should have been discarded, or `tbe` disagrees with the count of bytes written but not yet loaded. A lost idle/busy state shows up as a missing or extra `sh_load` on the cycle after a write or completion. Interrupt-policy and drain faults show as `tx_irq` or `rts_n` differing from the bench on the cycle after the event that should have moved them. The bench runs both builds side by side under the same writes, so depth-specific faults are told apart.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // advance a queue index with wrap at the configured depth
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // writer one step behind reader: no further slot may be used
  function automatic logic ring_full(input int unsigned wp, input int unsigned rp,
                                     input int unsigned depth);
    return wrap_inc(wp, depth) == rp;
  endfunction

  // interrupt policy: empty-only mode looks at pointer equality, else at room flag
  function automatic logic irq_due(input logic empty_only, input logic ptr_eq,
                                   input logic room);
    return empty_only ? ptr_eq : room;
  endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == PW'(i))) slot_q[i] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/txq_irq.sv
module txq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_done,
  input  logic fire_wr,
  input  logic wr_acc,
  input  logic ack,
  output logic irq
);
  logic irq_d;

  always_comb begin
    if (fire_wr)     irq_d = 1'b1;
    else if (wr_acc) irq_d = 1'b0;
    else             irq_d = fire_done | (irq & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !fire_wr && !fire_done) |=> !irq) else $error("irq ack ignored"); // R11
endmodule

// File: rtl/txq_rate.sv
module txq_rate #(
  parameter int          BW       = 16,
  parameter logic [BW-1:0] BAUD_RST = 16'd12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [BW-1:0] val,
  input  logic          apply,
  output logic [BW-1:0] div
);
  logic          pend_q;
  logic [BW-1:0] pval_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pval_q <= BAUD_RST;
      div    <= BAUD_RST;
    end else begin
      if (apply && pend_q) div <= pval_q;
      if (req) begin
        pend_q <= 1'b1;
        pval_q <= val;
      end else if (apply) begin
        pend_q <= 1'b0;
      end
    end
  end

  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(div)) else $error("divisor moved off boundary"); // R10
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int            ENHANCED = 1,
  parameter int            DW       = 8,
  parameter int            BW       = 16,
  parameter logic [BW-1:0] BAUD_RST = 16'd12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          tx_enable,
  input  logic          send_break,
  input  logic          int_enable,
  input  logic          empty_irq_mode,
  input  logic          irq_ack,
  input  logic          rts_ctl,
  input  logic          baud_req,
  input  logic [BW-1:0] baud_val,
  input  logic          sh_done,
  output logic          sh_load,
  output logic [DW-1:0] sh_data,
  output logic          tbe,
  output logic          all_sent,
  output logic          tx_irq,
  output logic          rts_n,
  output logic [BW-1:0] baud_div
);
  import txq_pkg::*;

  localparam int DEPTH = (ENHANCED != 0) ? 4 : 1;
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] wp_q, rp_q;
  logic          busy_q;
  logic [DW-1:0] rd_data;
  logic          empty_only;

  // named internal events
  logic          done_live, done_load, drain_evt, fire_done;
  logic          wr_acc, wr_load, fire_wr, load_evt;
  logic [PW-1:0] rp_a, rp_b, wp_b;
  logic          tbe_a, tbe_b, sent_a, sent_b, busy_a, busy_b;
  logic [DW-1:0] load_byte;

  assign empty_only = (ENHANCED != 0) && empty_irq_mode;

  txq_store #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_store (
    .clk(clk), .we(wr_acc), .waddr(wp_q), .wdata(wr_data),
    .raddr(rp_q), .rdata(rd_data)
  );

  // completion step first, then the host write
  always_comb begin
    rp_a      = rp_q;
    tbe_a     = tbe;
    sent_a    = all_sent;
    busy_a    = busy_q;
    done_live = sh_done && tx_enable && !send_break;
    done_load = 1'b0;
    drain_evt = 1'b0;
    fire_done = 1'b0;
    if (sh_done) begin
      busy_a = 1'b0;
      if (done_live) begin
        if (!tbe || (rp_q != wp_q)) begin
          done_load = 1'b1;
          busy_a    = 1'b1;
          rp_a      = PW'(wrap_inc(rp_q, DEPTH));
          tbe_a     = 1'b1;
        end else begin
          sent_a    = 1'b1;
          drain_evt = 1'b1;
        end
        fire_done = int_enable && irq_due(empty_only, rp_a == wp_q, tbe_a);
      end
    end

    wr_acc  = wr_en && !(!tbe_a && ring_full(wp_q, rp_a, DEPTH));
    wp_b    = wp_q;
    rp_b    = rp_a;
    tbe_b   = tbe_a;
    sent_b  = sent_a;
    busy_b  = busy_a;
    wr_load = 1'b0;
    if (wr_acc) begin
      wp_b   = PW'(wrap_inc(wp_q, DEPTH));
      tbe_b  = (DEPTH == 1) ? 1'b0 : !ring_full(wp_b, rp_a, DEPTH);
      sent_b = 1'b0;
      if (tx_enable && !busy_a) begin
        wr_load = 1'b1;
        busy_b  = 1'b1;
        rp_b    = PW'(wrap_inc(rp_a, DEPTH));
        tbe_b   = 1'b1;
      end
    end
    fire_wr = wr_en && int_enable && irq_due(empty_only, rp_b == wp_b, tbe_b);

    load_evt  = done_load | wr_load;
    // a write-triggered load takes the new byte only when nothing was waiting
    load_byte = (wr_load && (rp_q == wp_q)) ? wr_data : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q     <= '0;
      rp_q     <= '0;
      busy_q   <= 1'b0;
      tbe      <= 1'b1;
      all_sent <= 1'b1;
      rts_n    <= 1'b1;
      sh_load  <= 1'b0;
      sh_data  <= '0;
    end else begin
      wp_q     <= wp_b;
      rp_q     <= rp_b;
      busy_q   <= busy_b;
      tbe      <= tbe_b;
      all_sent <= sent_b;
      sh_load  <= load_evt;
      if (load_evt) sh_data <= load_byte;
      if (rts_ctl)        rts_n <= 1'b0;
      else if (drain_evt) rts_n <= 1'b1;
    end
  end

  txq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .fire_done(fire_done), .fire_wr(fire_wr),
    .wr_acc(wr_acc), .ack(irq_ack), .irq(tx_irq)
  );

  txq_rate #(.BW(BW), .BAUD_RST(BAUD_RST)) u_rate (
    .clk(clk), .rst_n(rst_n), .req(baud_req), .val(baud_val),
    .apply(sh_done), .div(baud_div)
  );

  AST_SENT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !all_sent) else $error("all_sent survived write"); // R4
  AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_evt && !rts_ctl) |=> rts_n) else $error("rts not released"); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> $past(int_enable)) else $error("irq without enable"); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tbe && !sh_done) |=> $stable(wp_q)) else $error("write into full queue"); // R2
endmodule

// File: tb/txq_ctrl_tb.sv
module txq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BRST = 16'd12;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, tx_enable = 0, send_break = 0, int_enable = 0, empty_irq_mode = 0;
  logic irq_ack = 0, rts_ctl = 0, baud_req = 0;
  logic [7:0]  wr_data = 0;
  logic [15:0] baud_val = 0;
  logic        done_v [2];
  logic        o_load [2], o_tbe [2], o_sent [2], o_irq [2], o_rts [2];
  logic [7:0]  o_data [2];
  logic [15:0] o_baud [2];

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_ctrl #(.ENHANCED(1), .BAUD_RST(BRST)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tx_enable(tx_enable),
    .send_break(send_break), .int_enable(int_enable), .empty_irq_mode(empty_irq_mode),
    .irq_ack(irq_ack), .rts_ctl(rts_ctl), .baud_req(baud_req), .baud_val(baud_val),
    .sh_done(done_v[0]), .sh_load(o_load[0]), .sh_data(o_data[0]), .tbe(o_tbe[0]),
    .all_sent(o_sent[0]), .tx_irq(o_irq[0]), .rts_n(o_rts[0]), .baud_div(o_baud[0]));

  txq_ctrl #(.ENHANCED(0), .BAUD_RST(BRST)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tx_enable(tx_enable),
    .send_break(send_break), .int_enable(int_enable), .empty_irq_mode(empty_irq_mode),
    .irq_ack(irq_ack), .rts_ctl(rts_ctl), .baud_req(baud_req), .baud_val(baud_val),
    .sh_done(done_v[1]), .sh_load(o_load[1]), .sh_data(o_data[1]), .tbe(o_tbe[1]),
    .all_sent(o_sent[1]), .tx_irq(o_irq[1]), .rts_n(o_rts[1]), .baud_div(o_baud[1]));

  // bench model: count of waiting bytes, oldest first
  logic [7:0]  m_buf  [2][4];
  int          m_cnt  [2];
  logic        m_busy [2], m_sent [2], m_irq [2], m_rts [2], m_load [2], m_pend [2];
  logic [7:0]  m_data [2];
  logic [15:0] m_baud [2], m_pval [2];

  function automatic int cap_of(int d);
    return (d == 0) ? 3 : 1;   // R1: enhanced keeps 3 waiting, basic 1
  endfunction

  function automatic logic policy(int d);
    if (d == 0 && empty_irq_mode) return m_cnt[d] == 0;
    return m_cnt[d] < cap_of(d);
  endfunction

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      m_cnt[d] = 0; m_busy[d] = 0; m_sent[d] = 1; m_irq[d] = 0; m_rts[d] = 1;
      m_load[d] = 0; m_pend[d] = 0; m_baud[d] = BRST; m_pval[d] = BRST;
    end
  endtask

  task automatic pop(int d);
    m_data[d] = m_buf[d][0];
    for (int k = 0; k < 3; k++) m_buf[d][k] = m_buf[d][k+1];
    m_cnt[d]--;
    m_load[d] = 1; m_busy[d] = 1;
  endtask

  task automatic model_step(int d);
    logic fd, fw, acc, drain;
    fd = 0; fw = 0; acc = 0; drain = 0; m_load[d] = 0;
    if (done_v[d]) begin
      if (m_pend[d]) begin m_baud[d] = m_pval[d]; m_pend[d] = 0; end
      m_busy[d] = 0;
      if (tx_enable && !send_break) begin
        if (m_cnt[d] > 0) pop(d);
        else begin m_sent[d] = 1; drain = 1; end
        fd = int_enable && policy(d);
      end
    end
    if (wr_en) begin
      acc = m_cnt[d] < cap_of(d);
      if (acc) begin
        m_buf[d][m_cnt[d]] = wr_data; m_cnt[d]++; m_sent[d] = 0;
        if (tx_enable && !m_busy[d]) pop(d);
      end
      fw = int_enable && policy(d);
    end
    m_irq[d] = fw | (acc ? 1'b0 : (fd | (m_irq[d] & !irq_ack)));
    if (rts_ctl) m_rts[d] = 0; else if (drain) m_rts[d] = 1;
    if (baud_req) begin m_pend[d] = 1; m_pval[d] = baud_val; end
  endtask

  task automatic chk(logic ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    for (int d = 0; d < 2; d++) begin
      chk(o_tbe[d] == (m_cnt[d] < cap_of(d)), "R3 tbe", o_tbe[d], m_cnt[d] < cap_of(d));
      chk(o_sent[d] == m_sent[d], "R6 all_sent", o_sent[d], m_sent[d]);
      chk(o_irq[d] == m_irq[d], "R8 tx_irq", o_irq[d], m_irq[d]);
      chk(o_rts[d] == m_rts[d], "R7 rts_n", o_rts[d], m_rts[d]);
      chk(o_load[d] == m_load[d], "R5 sh_load", o_load[d], m_load[d]);
      if (m_load[d]) chk(o_data[d] == m_data[d], "R2 sh_data", o_data[d], m_data[d]);
      chk(o_baud[d] == m_baud[d], "R10 baud_div", o_baud[d], m_baud[d]);
    end
  endtask

  // called at a negedge with inputs set; returns at the next negedge
  task automatic cycle();
    for (int d = 0; d < 2; d++) model_step(d);
    @(posedge clk); #1;
    compare();
    @(negedge clk);
    wr_en = 0; irq_ack = 0; baud_req = 0; done_v[0] = 0; done_v[1] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    wr_en = 0; irq_ack = 0; baud_req = 0; done_v[0] = 0; done_v[1] = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic write(logic [7:0] b);
    wr_en = 1; wr_data = b; cycle();
  endtask

  task automatic finish_all(int d);
    done_v[d] = 1; cycle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    done_v[0] = 0; done_v[1] = 0;
    model_reset();
    do_reset();
    #1;
    for (int d = 0; d < 2; d++) begin  // R12 reset values
      chk(o_tbe[d] && o_sent[d] && !o_irq[d] && o_rts[d] && !o_load[d], "R12 reset flags",
          {o_tbe[d], o_sent[d], o_irq[d], o_rts[d], o_load[d]}, 5'b11010);
      chk(o_baud[d] == BRST, "R12 reset baud", o_baud[d], BRST);
    end

    // R9: enabling interrupts alone raises nothing
    int_enable = 1;
    repeat (4) cycle();
    chk(!o_irq[0] && !o_irq[1], "R9 no irq on enable", {o_irq[0], o_irq[1]}, 0);

    // R1/R2: burst of five writes with transmitter running
    tx_enable = 1;
    for (int i = 0; i < 5; i++) write(8'hA0 + 8'(i));
    chk(!o_tbe[0] && !o_tbe[1], "R1 both full", {o_tbe[0], o_tbe[1]}, 0);
    chk(m_cnt[0] == 3 && m_cnt[1] == 1, "R1 waiting count", m_cnt[0], 3);
    // R11: ack clears level
    irq_ack = 1; cycle();
    chk(!o_irq[0] && !o_irq[1], "R11 ack clears", {o_irq[0], o_irq[1]}, 0);
    // R10: divisor held until completion
    baud_req = 1; baud_val = 16'd77; cycle();
    chk(o_baud[0] == BRST, "R10 held", o_baud[0], BRST);
    // drain both; sh_data sequence checked by compare (R2, R6)
    for (int i = 0; i < 5; i++) begin
      for (int d = 0; d < 2; d++) done_v[d] = m_busy[d];
      cycle();
    end
    chk(o_baud[0] == 16'd77, "R10 applied", o_baud[0], 77);
    chk(o_sent[0] && o_sent[1], "R6 drained", {o_sent[0], o_sent[1]}, 3);

    // R13: completion while disabled loads nothing
    write(8'h55);
    tx_enable = 0; write(8'h66);
    finish_all(0);
    chk(!o_load[0], "R13 no load when disabled", o_load[0], 0);

    // R8: enhanced empty-only policy
    do_reset();
    tx_enable = 1; int_enable = 1; empty_irq_mode = 1;
    write(8'h11);
    chk(o_irq[0] == 1, "R8 empty queue fires", o_irq[0], 1);
    write(8'h22);
    chk(o_irq[0] == 0, "R8 non-empty holds off", o_irq[0], 0);

    // R7: rts asserted then released on drain
    rts_ctl = 1; cycle();
    chk(!o_rts[0], "R7 rts asserted", o_rts[0], 0);
    rts_ctl = 0;
    for (int i = 0; i < 3; i++) begin
      for (int d = 0; d < 2; d++) done_v[d] = m_busy[d];
      cycle();
    end

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if (n % 250 == 0) do_reset();
      wr_en          = ($urandom % 3) == 0;
      wr_data        = 8'($urandom);
      tx_enable      = ($urandom % 20) != 0;
      send_break     = ($urandom % 40) == 0;
      int_enable     = ($urandom % 4) != 0;
      empty_irq_mode = ($urandom % 2) == 0;
      irq_ack        = ($urandom % 6) == 0;
      rts_ctl        = ($urandom % 8) == 0;
      baud_req       = ($urandom % 30) == 0;
      baud_val       = 16'($urandom);
      for (int d = 0; d < 2; d++) done_v[d] = m_busy[d] && (($urandom % 3) == 0);
      cycle();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    process p;
    p = process::self();
    void'($urandom(32'd1234));
  end
endmodule